// File: doc/BRIEF.md
# Debug-Mode Translation Bypass Unit

This block sits beside a small fully associative address-translation table and decides, access by access, whether an effective address goes through normal page translation or through a debug bypass. The bypass applies only while the core is in a debug session. A session begins when the core enters debug mode. It ends only when a go command carrying the exit qualifier executes; a plain go command leaves it running.

When the session flag and the translation-disable control bit are both set, the real address equals the effective address and no table result is used. The six protection bits are all granted and the page attributes come from debug control bits, so these attributes govern caching for every access the core issues during that time. No translation miss and no storage fault is raised. At any other time the table supplies the real page number, the protection bits and the attributes, and misses and permission faults are reported. The table has eight entries with 4 KB pages and is loaded through a write port.

Top module: `dbg_xlate_bypass`

## Requirements
- R1: After reset no session is active. A pulse on `dbg_enter_i` starts a session at the next clock edge. A pulse on `go_cmd_i` with `go_exit_i` high, and no enter in the same cycle, ends it at the next edge.
- R2: While a session is active and `xlat_dis_i` is 1, `ra_o` equals `ea_i` in the same cycle.
- R3: While bypass is active, `prot_o` is 6'b111111. Bit order is {user execute, user read, user write, supervisor execute, supervisor read, supervisor write}, with user execute at bit 5.
- R4: While bypass is active, `attr_o` equals `dbg_attr_i`. Bit order is {variable-length encoding, write-through, cache-inhibit, coherence-required, guarded, little-endian}, with the first at bit 5.
- R5: While bypass is active, `tlb_miss_o` and `stor_fault_o` are 0 whatever the table holds.
- R6: In a session with `xlat_dis_i` at 0, translation, miss and fault reporting behave exactly as outside a session.
- R7: Outside a session `xlat_dis_i` has no effect on any output.
- R8: On a table hit, `ra_o` = {entry real page, `ea_i[11:0]`}, and `prot_o` and `attr_o` are the entry's fields.
- R9: When no valid entry matches `ea_i[31:12]`, `tlb_miss_o` is 1 and `ra_o`, `prot_o`, `attr_o` and `stor_fault_o` are 0.
- R10: On a hit, `stor_fault_o` is 1 exactly when the protection bit picked by `acc_i` and `sup_i` is 0. Access codes are 00 fetch (execute), 01 load (read), and 10 or 11 store (write). `sup_i`=1 picks the supervisor bits.
- R11: When several valid entries match, the lowest-indexed one supplies the result.
- R12: A go command without the exit qualifier does not end a session. An enter pulse in the same cycle as go-with-exit leaves the session active.
- R13: A table write at a clock edge is visible from the next cycle. Writing an entry with valid 0 removes it from lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_enter_i | input | 1 | Core entered debug mode (pulse) |
| go_cmd_i | input | 1 | Go command executed (pulse) |
| go_exit_i | input | 1 | Exit qualifier of the go command |
| xlat_dis_i | input | 1 | Translation-disable control bit |
| dbg_attr_i | input | 6 | Substitute page attributes |
| ea_i | input | EA_W | Effective address |
| acc_i | input | 2 | Access type |
| sup_i | input | 1 | Supervisor privilege |
| tlb_we_i | input | 1 | Table write strobe |
| tlb_widx_i | input | IDX_W | Entry index written |
| tlb_wvalid_i | input | 1 | Valid bit written |
| tlb_wvpn_i | input | EA_W-PG_W | Virtual page written |
| tlb_wrpn_i | input | EA_W-PG_W | Real page written |
| tlb_wprot_i | input | 6 | Protection bits written |
| tlb_wattr_i | input | 6 | Attributes written |
| ra_o | output | EA_W | Real address |
| prot_o | output | 6 | Effective protection bits |
| attr_o | output | 6 | Effective page attributes |
| tlb_miss_o | output | 1 | Translation miss |
| stor_fault_o | output | 1 | Protection fault on a hit |

## Verification
The hardest situations to reach are the edges of the session. One is a go command without the exit qualifier. Another is an enter pulse landing in the same cycle as go-with-exit. A third is bypass hiding an address that would otherwise miss or fault. The bench drives those pulses explicitly and then sweeps every table entry, every access type and both privilege levels, each in four contexts: inside and outside a session, with the disable bit set and clear. It also writes a duplicate virtual page into a higher entry to test the ordering, and invalidates an entry to confirm that the address then misses.

// File: rtl/dxb_pkg.sv
package dxb_pkg;

    typedef struct packed {
        logic ux;
        logic ur;
        logic uw;
        logic sx;
        logic sr;
        logic sw;
    } prot_t;

    typedef struct packed {
        logic vle;
        logic wt;
        logic ci;
        logic coh;
        logic grd;
        logic le;
    } attr_t;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_STX   = 2'b11
    } acc_e;

    localparam prot_t PROT_ALL = '{ux: 1'b1, ur: 1'b1, uw: 1'b1,
                                   sx: 1'b1, sr: 1'b1, sw: 1'b1};

    function automatic logic perm_ok(input prot_t p, input logic [1:0] acc,
                                     input logic sup);
        logic x, r, w;
        x = sup ? p.sx : p.ux;
        r = sup ? p.sr : p.ur;
        w = sup ? p.sw : p.uw;
        if (acc[1])      return w;
        else if (acc[0]) return r;
        else             return x;
    endfunction

endpackage

// File: rtl/dxb_session.sv
module dxb_session (
    input  logic clk,
    input  logic rst,
    input  logic enter_i,
    input  logic go_i,
    input  logic exit_i,
    output logic active_o
);
    logic sess_q;
    logic leave;

    assign leave = go_i && exit_i;

    always_ff @(posedge clk) begin
        if (rst)          sess_q <= 1'b0;
        else if (enter_i) sess_q <= 1'b1;
        else if (leave)   sess_q <= 1'b0;
    end

    assign active_o = sess_q;

    AST_SESS_ENTER: assert property (@(posedge clk) disable iff (rst)
        enter_i |=> sess_q);                                   // R1
    AST_SESS_EXIT: assert property (@(posedge clk) disable iff (rst)
        (go_i && exit_i && !enter_i) |=> !sess_q);             // R1
    AST_SESS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!enter_i && !(go_i && exit_i)) |=> $stable(sess_q));  // R12

endmodule

// File: rtl/dxb_tlb.sv
module dxb_tlb
    import dxb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic             wvalid_i,
    input  logic [VPN_W-1:0] wvpn_i,
    input  logic [VPN_W-1:0] wrpn_i,
    input  prot_t            wprot_i,
    input  attr_t            wattr_i,
    input  logic [VPN_W-1:0] vpn_i,
    output logic             hit_o,
    output logic [VPN_W-1:0] rpn_o,
    output prot_t            prot_o,
    output attr_t            attr_o
);
    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [VPN_W-1:0]   rpn_q  [ENTRIES];
    prot_t              prot_q [ENTRIES];
    attr_t              attr_q [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] sel;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
                vpn_q[g]   <= '0;
                rpn_q[g]   <= '0;
                prot_q[g]  <= '0;
                attr_q[g]  <= '0;
            end else if (we_i && widx_i == IDX_W'(g)) begin
                valid_q[g] <= wvalid_i;
                vpn_q[g]   <= wvpn_i;
                rpn_q[g]   <= wrpn_i;
                prot_q[g]  <= wprot_i;
                attr_q[g]  <= wattr_i;
            end
        end
        assign match[g] = valid_q[g] && (vpn_q[g] == vpn_i);
    end

    always_comb begin
        logic taken;
        taken = 1'b0;
        sel   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i] && !taken) begin
                sel[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    always_comb begin
        rpn_o  = '0;
        prot_o = '0;
        attr_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (sel[i]) begin
                rpn_o  = rpn_o  | rpn_q[i];
                prot_o = prot_o | prot_q[i];
                attr_o = attr_o | attr_q[i];
            end
        end
    end

    assign hit_o = |match;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel) && ((sel & ~match) == '0));                  // R11
    AST_WR_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        we_i |=> valid_q[$past(widx_i)] == $past(wvalid_i));       // R13

endmodule

// File: rtl/dxb_select.sv
module dxb_select
    import dxb_pkg::*;
#(
    parameter int EA_W = 32,
    parameter int PG_W = 12,
    localparam int VPN_W = EA_W - PG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bypass_i,
    input  attr_t            dbg_attr_i,
    input  logic [EA_W-1:0]  ea_i,
    input  logic [1:0]       acc_i,
    input  logic             sup_i,
    input  logic             hit_i,
    input  logic [VPN_W-1:0] rpn_i,
    input  prot_t            prot_i,
    input  attr_t            attr_i,
    output logic [EA_W-1:0]  ra_o,
    output prot_t            prot_o,
    output attr_t            attr_o,
    output logic             miss_o,
    output logic             fault_o
);
    always_comb begin
        if (bypass_i) begin
            ra_o    = ea_i;
            prot_o  = PROT_ALL;
            attr_o  = dbg_attr_i;
            miss_o  = 1'b0;
            fault_o = 1'b0;
        end else if (hit_i) begin
            ra_o    = {rpn_i, ea_i[PG_W-1:0]};
            prot_o  = prot_i;
            attr_o  = attr_i;
            miss_o  = 1'b0;
            fault_o = !perm_ok(prot_i, acc_i, sup_i);
        end else begin
            ra_o    = '0;
            prot_o  = '0;
            attr_o  = '0;
            miss_o  = 1'b1;
            fault_o = 1'b0;
        end
    end

    AST_BYP_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        bypass_i |-> (ra_o == ea_i) && (prot_o == PROT_ALL));  // R2
    AST_BYP_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        bypass_i |-> !miss_o && !fault_o);                    // R5
    AST_MISS_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(miss_o && fault_o));                                 // R9
    AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (!bypass_i && hit_i) |-> ra_o[PG_W-1:0] == ea_i[PG_W-1:0]); // R8

endmodule

// File: rtl/dbg_xlate_bypass.sv
module dbg_xlate_bypass
    import dxb_pkg::*;
#(
    parameter int EA_W    = 32,
    parameter int PG_W    = 12,
    parameter int ENTRIES = 8,
    localparam int VPN_W  = EA_W - PG_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dbg_enter_i,
    input  logic             go_cmd_i,
    input  logic             go_exit_i,
    input  logic             xlat_dis_i,
    input  logic [5:0]       dbg_attr_i,
    input  logic [EA_W-1:0]  ea_i,
    input  logic [1:0]       acc_i,
    input  logic             sup_i,
    input  logic             tlb_we_i,
    input  logic [IDX_W-1:0] tlb_widx_i,
    input  logic             tlb_wvalid_i,
    input  logic [VPN_W-1:0] tlb_wvpn_i,
    input  logic [VPN_W-1:0] tlb_wrpn_i,
    input  logic [5:0]       tlb_wprot_i,
    input  logic [5:0]       tlb_wattr_i,
    output logic [EA_W-1:0]  ra_o,
    output logic [5:0]       prot_o,
    output logic [5:0]       attr_o,
    output logic             tlb_miss_o,
    output logic             stor_fault_o
);
    logic             in_session;
    logic             bypass;
    logic             hit;
    logic [VPN_W-1:0] t_rpn;
    prot_t            t_prot;
    attr_t            t_attr;
    prot_t            o_prot;
    attr_t            o_attr;

    dxb_session u_sess (
        .clk      (clk),
        .rst      (rst),
        .enter_i  (dbg_enter_i),
        .go_i     (go_cmd_i),
        .exit_i   (go_exit_i),
        .active_o (in_session)
    );

    assign bypass = in_session && xlat_dis_i;

    dxb_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_tlb (
        .clk      (clk),
        .rst      (rst),
        .we_i     (tlb_we_i),
        .widx_i   (tlb_widx_i),
        .wvalid_i (tlb_wvalid_i),
        .wvpn_i   (tlb_wvpn_i),
        .wrpn_i   (tlb_wrpn_i),
        .wprot_i  (prot_t'(tlb_wprot_i)),
        .wattr_i  (attr_t'(tlb_wattr_i)),
        .vpn_i    (ea_i[EA_W-1:PG_W]),
        .hit_o    (hit),
        .rpn_o    (t_rpn),
        .prot_o   (t_prot),
        .attr_o   (t_attr)
    );

    dxb_select #(.EA_W(EA_W), .PG_W(PG_W)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .bypass_i   (bypass),
        .dbg_attr_i (attr_t'(dbg_attr_i)),
        .ea_i       (ea_i),
        .acc_i      (acc_i),
        .sup_i      (sup_i),
        .hit_i      (hit),
        .rpn_i      (t_rpn),
        .prot_i     (t_prot),
        .attr_i     (t_attr),
        .ra_o       (ra_o),
        .prot_o     (o_prot),
        .attr_o     (o_attr),
        .miss_o     (tlb_miss_o),
        .fault_o    (stor_fault_o)
    );

    assign prot_o = o_prot;
    assign attr_o = o_attr;

    AST_OUTSIDE_NORMAL: assert property (@(posedge clk) disable iff (rst)
        (!in_session && !hit) |-> tlb_miss_o);                 // R7
    AST_BYP_ATTR: assert property (@(posedge clk) disable iff (rst)
        bypass |-> attr_o == dbg_attr_i);                      // R4

endmodule

// File: tb/dbg_xlate_bypass_tb.sv
module dbg_xlate_bypass_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        dbg_enter_i, go_cmd_i, go_exit_i, xlat_dis_i;
    logic [5:0]  dbg_attr_i;
    logic [31:0] ea_i;
    logic [1:0]  acc_i;
    logic        sup_i;
    logic        tlb_we_i;
    logic [2:0]  tlb_widx_i;
    logic        tlb_wvalid_i;
    logic [19:0] tlb_wvpn_i, tlb_wrpn_i;
    logic [5:0]  tlb_wprot_i, tlb_wattr_i;
    logic [31:0] ra_o;
    logic [5:0]  prot_o, attr_o;
    logic        tlb_miss_o, stor_fault_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    bit        m_val  [8];
    bit [19:0] m_vpn  [8];
    bit [19:0] m_rpn  [8];
    bit [5:0]  m_prot [8];
    bit [5:0]  m_attr [8];
    bit        m_sess;

    always #(CLK_P/2) clk = ~clk;

    dbg_xlate_bypass u_dut (
        .clk(clk), .rst(rst),
        .dbg_enter_i(dbg_enter_i), .go_cmd_i(go_cmd_i), .go_exit_i(go_exit_i),
        .xlat_dis_i(xlat_dis_i), .dbg_attr_i(dbg_attr_i),
        .ea_i(ea_i), .acc_i(acc_i), .sup_i(sup_i),
        .tlb_we_i(tlb_we_i), .tlb_widx_i(tlb_widx_i), .tlb_wvalid_i(tlb_wvalid_i),
        .tlb_wvpn_i(tlb_wvpn_i), .tlb_wrpn_i(tlb_wrpn_i),
        .tlb_wprot_i(tlb_wprot_i), .tlb_wattr_i(tlb_wattr_i),
        .ra_o(ra_o), .prot_o(prot_o), .attr_o(attr_o),
        .tlb_miss_o(tlb_miss_o), .stor_fault_o(stor_fault_o)
    );

    // Expected outputs from the requirements; bit 5 of prot is user execute.
    task automatic expect_of(input bit [31:0] ea, input bit [1:0] acc, input bit sup,
                             output bit [31:0] ra, output bit [5:0] pr,
                             output bit [5:0] at, output bit ms, output bit ft);
        int hit_idx = -1;
        bit need;
        if (m_sess && xlat_dis_i) begin
            ra = ea; pr = 6'h3f; at = dbg_attr_i; ms = 0; ft = 0;
            return;
        end
        for (int i = 7; i >= 0; i--)
            if (m_val[i] && m_vpn[i] == ea[31:12]) hit_idx = i;
        if (hit_idx < 0) begin
            ra = 0; pr = 0; at = 0; ms = 1; ft = 0;
            return;
        end
        ra = {m_rpn[hit_idx], ea[11:0]};
        pr = m_prot[hit_idx];
        at = m_attr[hit_idx];
        ms = 0;
        // index of permission bit: fetch 5/2, load 4/1, store 3/0
        need = pr[(sup ? 2 : 5) - (acc[1] ? 2 : (acc[0] ? 1 : 0))];
        ft = !need;
    endtask

    task automatic look(input string tag, input bit [31:0] ea,
                        input bit [1:0] acc, input bit sup);
        bit [31:0] e_ra; bit [5:0] e_pr, e_at; bit e_ms, e_ft;
        @(negedge clk);
        ea_i = ea; acc_i = acc; sup_i = sup;
        #1;
        expect_of(ea, acc, sup, e_ra, e_pr, e_at, e_ms, e_ft);
        total++;
        if (ra_o !== e_ra || prot_o !== e_pr || attr_o !== e_at ||
            tlb_miss_o !== e_ms || stor_fault_o !== e_ft) begin
            bad++;
            $display("FAIL %s ea=%h: got ra=%h prot=%b attr=%b miss=%b flt=%b exp ra=%h prot=%b attr=%b miss=%b flt=%b",
                     tag, ea, ra_o, prot_o, attr_o, tlb_miss_o, stor_fault_o,
                     e_ra, e_pr, e_at, e_ms, e_ft);
        end
    endtask

    task automatic wr(input int idx, input bit v, input bit [19:0] vpn,
                      input bit [19:0] rpn, input bit [5:0] pr, input bit [5:0] at);
        @(negedge clk);
        tlb_we_i = 1; tlb_widx_i = 3'(idx); tlb_wvalid_i = v;
        tlb_wvpn_i = vpn; tlb_wrpn_i = rpn; tlb_wprot_i = pr; tlb_wattr_i = at;
        @(posedge clk);
        #1 tlb_we_i = 0;
        m_val[idx] = v; m_vpn[idx] = vpn; m_rpn[idx] = rpn;
        m_prot[idx] = pr; m_attr[idx] = at;
    endtask

    task automatic ctl(input bit ent, input bit go, input bit ex);
        @(negedge clk);
        dbg_enter_i = ent; go_cmd_i = go; go_exit_i = ex;
        @(posedge clk);
        #1 dbg_enter_i = 0; go_cmd_i = 0; go_exit_i = 0;
        if (ent) m_sess = 1;
        else if (go && ex) m_sess = 0;
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 8; i++)
            for (int a = 0; a < 4; a++)
                for (int s = 0; s < 2; s++)
                    look(tag, {20'h00A00 + 20'(i * 17), 12'(i * 37 + a * 5 + s)},
                         2'(a), s[0]);
        look(tag, 32'h7777_7123, 2'b01, 1'b0);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_sess = 0;
        for (int i = 0; i < 8; i++) m_val[i] = 0;
        rst = 1; dbg_enter_i = 0; go_cmd_i = 0; go_exit_i = 0; xlat_dis_i = 1;
        dbg_attr_i = 6'b101101; ea_i = 0; acc_i = 0; sup_i = 0;
        tlb_we_i = 0; tlb_widx_i = 0; tlb_wvalid_i = 0;
        tlb_wvpn_i = 0; tlb_wrpn_i = 0; tlb_wprot_i = 0; tlb_wattr_i = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 R9 reset state: no session, empty table misses even with disable set
        look("R1_R9_reset", 32'h1234_5678, 2'b01, 1'b0);

        // R13 load the table
        for (int i = 0; i < 8; i++)
            wr(i, 1, 20'h00A00 + 20'(i * 17), 20'hF0000 + 20'(i * 257),
               6'(i * 13 + 7), 6'(i * 11 + 2));
        look("R13_written", 32'h00A00_abc, 2'b00, 1'b1);

        xlat_dis_i = 0;
        sweep("R8_R10_normal");
        xlat_dis_i = 1;
        sweep("R7_outside_dis_ignored");

        ctl(1, 0, 0);                      // R1 session starts
        sweep("R2_R3_R4_R5_bypass");
        dbg_attr_i = 6'b010010;
        look("R4_attr_change", 32'h7777_7000, 2'b10, 1'b1);
        xlat_dis_i = 0;
        sweep("R6_session_normal");
        xlat_dis_i = 1;

        ctl(0, 1, 0);                      // R12 go without exit
        look("R12_go_no_exit", 32'h5555_5001, 2'b00, 1'b0);
        ctl(0, 1, 1);                      // R1 go with exit
        look("R1_exit_ends", 32'h5555_5001, 2'b00, 1'b0);
        look("R1_exit_ends_hit", 32'h00A11_010, 2'b10, 1'b1);
        ctl(1, 1, 1);                      // R12 enter wins over exit
        look("R12_enter_and_exit", 32'h5555_5002, 2'b01, 1'b1);
        ctl(0, 1, 1);

        // R11 duplicate page in a higher entry
        wr(7, 1, 20'h00A22, 20'h0BEEF, 6'h00, 6'h3f);
        for (int a = 0; a < 3; a++)
            look("R11_lowest_wins", 32'h00A22_444, 2'(a), 1'b0);
        // R13 invalidate entry 3, then its page misses
        wr(3, 0, 20'h00A33, 20'hF0303, 6'h3f, 6'h00);
        look("R13_invalidate", 32'h00A33_020, 2'b01, 1'b1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule